// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit is one execution stage of an 8-bit processor that performs single-bit work on a byte operand. A request arrives with an operation code, the operand byte, and two possible sources for the bit number. One source is a 3-bit immediate. The other is a general register byte, of which only the low three bits are used. A select chooses between them.

The unit can set, clear or invert the chosen bit and hand back the modified byte for write-back. It can also test the bit into the zero flag, or fold the bit into the carry flag with AND or OR. For the AND and OR folds, the bit can optionally be inverted first. The inverted folds accept only an immediate bit number. A request that pairs one of them with the register source is rejected with an error.

The stage has no sequencing. It has one implicit state, a registered output stage, that is either reloaded by a valid strobe or holds. Reloading happens when `valid_i` is high at a rising edge. Holding is the other case: when `valid_i` is low, or when a rejected request leaves the flags alone. Reset returns the stage to all zeros.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `result_o`, `wb_o`, `c_o`, `z_o` and `err_o` to 0.
- R2: The bit number is `imm_bit_i` when `use_reg_i` is 0 and `reg_bit_i[2:0]` when `use_reg_i` is 1. Bits 7..3 of `reg_bit_i` are ignored, and so is the unselected source.
- R3: Operation codes are SET=0, CLR=1, INV=2. Each one makes `result_o` equal the operand with the selected bit forced to 1, forced to 0 or complemented, and every other bit unchanged. Each one sets `wb_o` to 1 and leaves `c_o` and `z_o` unchanged.
- R4: TST=3 writes the complement of the selected bit into `z_o`, so `z_o` is 1 when the bit is 0. It leaves `c_o` unchanged and sets `wb_o` to 0.
- R5: CAND=4 writes `c_i` AND bit into `c_o`. CIAND=5 writes `c_i` AND NOT bit into `c_o`.
- R6: COR=6 writes `c_i` OR bit into `c_o`. CIOR=7 writes `c_i` OR NOT bit into `c_o`.
- R7: The four carry operations (codes 4..7) leave `z_o` unchanged and set `wb_o` to 0.
- R8: CIAND or CIOR with `use_reg_i`=1 is illegal. It sets `err_o` to 1, sets `wb_o` to 0, and leaves `c_o` and `z_o` unchanged. Any legal request sets `err_o` to 0.
- R9: A rising edge with `valid_i` low leaves `result_o`, `c_o` and `z_o` unchanged and sets `wb_o` and `err_o` to 0.
- R10: Every output reflects a request exactly one clock edge after the edge that samples it. For operations that do not write back, `result_o` carries the unmodified operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..7) |
| operand_i | input | 8 | Byte operand |
| imm_bit_i | input | 3 | Immediate bit number |
| reg_bit_i | input | 8 | Register byte carrying a bit number in its low three bits |
| use_reg_i | input | 1 | 1 selects the register bit number |
| c_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| wb_o | output | 1 | Write-back enable for result_o |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| err_o | output | 1 | Illegal request flag |

## Verification
Two functions can meet in one cycle: the legality check and the carry-flag update. Both are driven by the same inverted-fold request. The bench sweeps every operation, bit number, source select and incoming carry over a set of operand patterns. This puts the register source on CIAND and CIOR with `c_i` values that would change the carry if the update were allowed. Such a cycle is judged correct only if `err_o` rises while `c_o`, `z_o` and `wb_o` keep their expected held values, all computed in the bench.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_CLR   = 3'd1,
        OP_INV   = 3'd2,
        OP_TST   = 3'd3,
        OP_CAND  = 3'd4,
        OP_CIAND = 3'd5,
        OP_COR   = 3'd6,
        OP_CIOR  = 3'd7
    } bitop_op_e;

    typedef struct packed {
        logic c_we;
        logic c_val;
        logic z_we;
        logic z_val;
        logic wb;
        logic err;
    } bitop_ctl_t;
endpackage

// File: rtl/bitop_index_sel.sv
module bitop_index_sel #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  imm_idx,
    input  logic [DATA_W-1:0] reg_byte,
    input  logic              use_reg,
    input  logic [DATA_W-1:0] operand,
    output logic [IDX_W-1:0]  idx,
    output logic              sel_bit
);
    always_comb begin
        idx     = use_reg ? reg_byte[IDX_W-1:0] : imm_idx;
        sel_bit = operand[idx];
    end
endmodule

// File: rtl/bitop_bit_rewrite.sv
module bitop_bit_rewrite
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  bitop_op_e         op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] rewritten
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic hit;
        assign hit = (idx == IDX_W'(g));
        always_comb begin
            unique case (op)
                OP_SET:  rewritten[g] = hit ? 1'b1 : operand[g];
                OP_CLR:  rewritten[g] = hit ? 1'b0 : operand[g];
                OP_INV:  rewritten[g] = operand[g] ^ hit;
                default: rewritten[g] = operand[g];
            endcase
        end
    end
endmodule

// File: rtl/bitop_flag_eval.sv
module bitop_flag_eval
    import bitop_pkg::*;
(
    input  bitop_op_e  op,
    input  logic       sel_bit,
    input  logic       use_reg,
    input  logic       c_in,
    output bitop_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (op)
            OP_SET, OP_CLR, OP_INV: ctl.wb = 1'b1;
            OP_TST: begin
                ctl.z_we  = 1'b1;
                ctl.z_val = ~sel_bit;
            end
            OP_CAND: begin
                ctl.c_we  = 1'b1;
                ctl.c_val = c_in & sel_bit;
            end
            OP_COR: begin
                ctl.c_we  = 1'b1;
                ctl.c_val = c_in | sel_bit;
            end
            OP_CIAND, OP_CIOR: begin
                if (use_reg) begin
                    ctl.err = 1'b1;
                end else begin
                    ctl.c_we  = 1'b1;
                    ctl.c_val = (op == OP_CIAND) ? (c_in & ~sel_bit)
                                                 : (c_in | ~sel_bit);
                end
            end
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = bitop_pkg::DATA_W,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  imm_bit_i,
    input  logic [DATA_W-1:0] reg_bit_i,
    input  logic              use_reg_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wb_o,
    output logic              c_o,
    output logic              z_o,
    output logic              err_o
);
    bitop_op_e         op;
    logic [IDX_W-1:0]  idx;
    logic              sel_bit;
    logic [DATA_W-1:0] rewritten;
    bitop_ctl_t        ctl;

    assign op = bitop_op_e'(op_i);

    bitop_index_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_idx (
        .imm_idx  (imm_bit_i),
        .reg_byte (reg_bit_i),
        .use_reg  (use_reg_i),
        .operand  (operand_i),
        .idx      (idx),
        .sel_bit  (sel_bit)
    );

    bitop_bit_rewrite #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rw (
        .op        (op),
        .idx       (idx),
        .operand   (operand_i),
        .rewritten (rewritten)
    );

    bitop_flag_eval u_flag (
        .op      (op),
        .sel_bit (sel_bit),
        .use_reg (use_reg_i),
        .c_in    (c_i),
        .ctl     (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            wb_o     <= 1'b0;
            c_o      <= 1'b0;
            z_o      <= 1'b0;
            err_o    <= 1'b0;
        end else if (valid_i) begin
            result_o <= ctl.wb ? rewritten : operand_i;
            wb_o     <= ctl.wb;
            err_o    <= ctl.err;
            if (ctl.c_we) c_o <= ctl.c_val;
            if (ctl.z_we) z_o <= ctl.z_val;
        end else begin
            wb_o  <= 1'b0;
            err_o <= 1'b0;
        end
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wb_o,
    input logic              c_o,
    input logic              z_o,
    input logic              err_o
);
    // R8
    err_excl_wb_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !wb_o);

    // R8
    err_holds_flags_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(c_o) && $stable(z_o)));

    // R3
    wb_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_o && !$past(rst)) |-> ($countones(result_o ^ $past(operand_i)) <= 1));

    // R4
    tst_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && !$past(rst) && $past(op_i) == 3'd3)
            |-> ($stable(c_o) && !wb_o));

    // R7
    carry_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && !$past(rst) && $past(op_i[2]))
            |-> ($stable(z_o) && !wb_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(valid_i) && !$past(rst))
            |-> ($stable(c_o) && $stable(z_o) && $stable(result_o) && !wb_o && !err_o));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .result_o  (result_o),
    .wb_o      (wb_o),
    .c_o       (c_o),
    .z_o       (z_o),
    .err_o     (err_o)
);

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       valid_i;
    logic [2:0] op_i;
    logic [7:0] operand_i;
    logic [2:0] imm_bit_i;
    logic [7:0] reg_bit_i;
    logic       use_reg_i;
    logic       c_i;
    logic [7:0] result_o;
    logic       wb_o, c_o, z_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] e_res;
    logic       e_wb, e_c, e_z, e_err;

    always #2 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .operand_i(operand_i), .imm_bit_i(imm_bit_i), .reg_bit_i(reg_bit_i),
        .use_reg_i(use_reg_i), .c_i(c_i), .result_o(result_o), .wb_o(wb_o),
        .c_o(c_o), .z_o(z_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op=%0d opnd=%h src=%0d)",
                     req, act, exp, op_i, operand_i, use_reg_i);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " result"}, result_o, e_res);
        chk({req, " wb"}, {7'd0, wb_o}, {7'd0, e_wb});
        chk({req, " c"}, {7'd0, c_o}, {7'd0, e_c});
        chk({req, " z"}, {7'd0, z_o}, {7'd0, e_z});
        chk({req, " err"}, {7'd0, err_o}, {7'd0, e_err});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; valid_i = 1'b1; op_i = 3'd0; operand_i = 8'hFF;
        imm_bit_i = 3'd0; reg_bit_i = 8'h00; use_reg_i = 1'b0; c_i = 1'b1;
        repeat (3) @(negedge clk);
        e_res = 8'h00; e_wb = 0; e_c = 0; e_z = 0; e_err = 0;
        chk_all("R1");
        rst = 1'b0;
        for (int p = 0; p < 16; p++) begin
            for (int o = 0; o < 8; o++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int c = 0; c < 2; c++) begin
                            logic [7:0] opnd, msk;
                            logic       bitv, ill;
                            string      tag;
                            opnd = 8'(p * 8'd23 + 8'h5A * (p & 1));
                            msk = 8'd1 << b;
                            bitv = opnd[b];
                            ill = (s == 1) && (o == 5 || o == 7);
                            valid_i = 1'b1;
                            op_i = 3'(o);
                            operand_i = opnd;
                            use_reg_i = s[0];
                            c_i = c[0];
                            // R2: unselected source carries a different bit number, high reg bits junk
                            if (s == 1) begin
                                reg_bit_i = {5'(p + o + 3), 3'(b)};
                                imm_bit_i = ~3'(b);
                            end else begin
                                reg_bit_i = {5'(p * 3 + 1), ~3'(b)};
                                imm_bit_i = 3'(b);
                            end
                            e_err = ill;
                            e_wb = !ill && (o < 3);
                            e_res = opnd;
                            tag = "R2";
                            case (o)
                                0: begin e_res = opnd | msk; tag = "R3"; end
                                1: begin e_res = opnd & ~msk; tag = "R3"; end
                                2: begin e_res = opnd ^ msk; tag = "R3"; end
                                3: begin e_z = ~bitv; tag = "R4"; end
                                4: begin e_c = c[0] & bitv; tag = "R5"; end
                                5: begin if (!ill) e_c = c[0] & ~bitv; tag = ill ? "R8" : "R5"; end
                                6: begin e_c = c[0] | bitv; tag = "R6"; end
                                default: begin if (!ill) e_c = c[0] | ~bitv; tag = ill ? "R8" : "R6"; end
                            endcase
                            @(negedge clk);
                            chk_all(s == 1 ? {tag, "/R2/R10"} : {tag, "/R10"});
                            if (((p + b) % 5) == 0) begin
                                // R9: idle cycle with disturbing inputs
                                valid_i = 1'b0;
                                op_i = 3'(7 - o);
                                operand_i = ~opnd;
                                c_i = ~c[0];
                                use_reg_i = 1'b0;
                                e_wb = 0; e_err = 0;
                                @(negedge clk);
                                chk_all("R9");
                            end
                        end
                    end
                end
            end
        end
        // R7: carry op after TST leaves Z from the test
        valid_i = 1'b1; op_i = 3'd3; operand_i = 8'h00; use_reg_i = 0; imm_bit_i = 3'd4; c_i = 0;
        e_z = 1; e_wb = 0; e_err = 0; e_res = 8'h00;
        @(negedge clk);
        chk_all("R4");
        op_i = 3'd6; operand_i = 8'hFF; c_i = 0; e_c = 1; e_res = 8'hFF;
        @(negedge clk);
        chk_all("R7");
        // R1: reset after activity
        rst = 1'b1;
        @(negedge clk);
        e_res = 0; e_wb = 0; e_c = 0; e_z = 0; e_err = 0;
        chk_all("R1");
        rst = 1'b0; valid_i = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule